// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Generator

This block raises and clears the port-to-port interrupt flags of a two-port memory. It watches the address, enable, semaphore-space select and write strobe of both ports. It reacts to ordinary accesses that land on the two uppermost words of the array. The memory array and the access arbitration are built elsewhere. This block only observes the port signals and drives one active-low interrupt line toward each side.

The uppermost word is the mailbox from the left port to the right port. A left write to it raises the right interrupt. A right read of it takes that interrupt down again. The word just below it serves the other direction. A right write to it raises the left interrupt, and a left read of it clears that interrupt. Both mailbox addresses are computed from the address-width parameter, so a deeper array moves them to its own top. Each access is sampled on the rising clock edge, and the flag it changes is visible on the output from that edge onward.

Top module: `mbx_irq_top`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released with no access, both irq_l_n and irq_r_n are high (1 = no interrupt).
- R2: A qualified left write (l_en=1, l_sem=0, l_wr=1) to the top address, with all ADDR_W bits set (0x7FFF for 15 bits), drives irq_r_n low from the next rising edge.
- R3: A qualified right read (r_en=1, r_sem=0, r_wr=0) of the top address drives irq_r_n high from the next rising edge, unless R6 applies.
- R4: A qualified right write to the address one below the top (0x7FFE for 15 bits) drives irq_l_n low from the next rising edge.
- R5: A qualified left read of the address one below the top drives irq_l_n high from the next rising edge, unless R6 applies.
- R6: When the set and clear events of one flag occur in the same cycle, the flag ends up set (output low).
- R7: An access with its enable low, or with its semaphore select high, has no effect on either interrupt output.
- R8: Any other access leaves both outputs unchanged. This covers other addresses, a port reading its own send word, and a port writing its own receive word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_addr | input | ADDR_W | Left port word address |
| l_en | input | 1 | Left port access enable, active high |
| l_sem | input | 1 | Left access targets semaphore space |
| l_wr | input | 1 | Left access is a write (0 = read) |
| r_addr | input | ADDR_W | Right port word address |
| r_en | input | 1 | Right port access enable, active high |
| r_sem | input | 1 | Right access targets semaphore space |
| r_wr | input | 1 | Right access is a write (0 = read) |
| irq_l_n | output | 1 | Interrupt toward the left port, active low |
| irq_r_n | output | 1 | Interrupt toward the right port, active low |

## Verification
On every cycle the assertions check four things. A qualified mailbox write pulls the peer's line low on the next edge. A receiving read releases it unless a set collides in the same cycle. A cycle without set or clear events leaves both lines stable. Disabled or semaphore-space accesses never produce a decoded event. The reset values cannot be seen by a clocked property, so only the bench's scenarios show them. The same holds for the effect of wrong-direction accesses and of near-miss addresses, which the bench sets up on purpose and then tracks through long random runs biased toward the two mailbox words.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  // Uppermost word of an array addressed by aw bits (aw <= 31).
  function automatic int unsigned mbx_top_word(input int unsigned aw);
    return (32'd1 << aw) - 32'd1;
  endfunction

  // Word just below the uppermost one.
  function automatic int unsigned mbx_next_word(input int unsigned aw);
    return mbx_top_word(aw) - 32'd1;
  endfunction

  // Only enabled accesses outside semaphore space count.
  function automatic acc_kind_t mbx_classify(input logic en, input logic sem,
                                             input logic wr);
    if (!en || sem) return ACC_IDLE;
    return wr ? ACC_WRITE : ACC_READ;
  endfunction

  // Next flag value; a set beats a clear.
  function automatic logic mbx_flag_next(input logic cur, input logic set,
                                         input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter bit          SEND_TOP = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  input  logic              sem,
  input  logic              wr,
  output logic              send_hit,
  output logic              take_hit
);

  localparam logic [ADDR_W-1:0] TOP_W  = ADDR_W'(mbx_top_word(ADDR_W));
  localparam logic [ADDR_W-1:0] NEXT_W = ADDR_W'(mbx_next_word(ADDR_W));
  localparam logic [ADDR_W-1:0] SEND_W = SEND_TOP ? TOP_W : NEXT_W;
  localparam logic [ADDR_W-1:0] TAKE_W = SEND_TOP ? NEXT_W : TOP_W;

  acc_kind_t kind;

  always_comb begin
    kind     = mbx_classify(en, sem, wr);
    send_hit = (kind == ACC_WRITE) && (addr == SEND_W);
    take_hit = (kind == ACC_READ)  && (addr == TAKE_W);
  end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
  import mbx_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= mbx_flag_next(flag_q, set, clr);
  end

  assign irq_n = ~flag_q;

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_en,
  input  logic              l_sem,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_en,
  input  logic              r_sem,
  input  logic              r_wr,
  output logic              irq_l_n,
  output logic              irq_r_n
);

  localparam int unsigned NPORT = 2;

  // Named events: left sends on the top word, right on the word below.
  logic l_send_hit, l_take_hit;
  logic r_send_hit, r_take_hit;

  mbx_port_dec #(.ADDR_W(ADDR_W), .SEND_TOP(1'b1)) u_dec_l (
    .addr(l_addr), .en(l_en), .sem(l_sem), .wr(l_wr),
    .send_hit(l_send_hit), .take_hit(l_take_hit)
  );

  mbx_port_dec #(.ADDR_W(ADDR_W), .SEND_TOP(1'b0)) u_dec_r (
    .addr(r_addr), .en(r_en), .sem(r_sem), .wr(r_wr),
    .send_hit(r_send_hit), .take_hit(r_take_hit)
  );

  // Index 0: flag toward left, index 1: flag toward right.
  logic [NPORT-1:0] flag_set, flag_clr, flag_irq_n;

  assign flag_set = {l_send_hit, r_send_hit};
  assign flag_clr = {r_take_hit, l_take_hit};

  for (genvar g = 0; g < NPORT; g++) begin : g_flag
    mbx_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(flag_set[g]), .clr(flag_clr[g]),
      .irq_n(flag_irq_n[g])
    );
  end

  assign irq_l_n = flag_irq_n[0];
  assign irq_r_n = flag_irq_n[1];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_en,
  input logic              l_sem,
  input logic              l_wr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_en,
  input logic              r_sem,
  input logic              r_wr,
  input logic              irq_l_n,
  input logic              irq_r_n,
  input logic              l_send_hit,
  input logic              l_take_hit,
  input logic              r_send_hit,
  input logic              r_take_hit
);

  localparam logic [ADDR_W-1:0] TOPW = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NXTW = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic l_ok, r_ok;
  assign l_ok = l_en && !l_sem;
  assign r_ok = r_en && !r_sem;

  assert_l_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ok && l_wr && l_addr == TOPW) |=> !irq_r_n);

  assert_r_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_ok && !r_wr && r_addr == TOPW && !(l_ok && l_wr && l_addr == TOPW))
      |=> irq_r_n);

  assert_r_send_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_ok && r_wr && r_addr == NXTW) |=> !irq_l_n);

  assert_l_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ok && !l_wr && l_addr == NXTW && !(r_ok && r_wr && r_addr == NXTW))
      |=> irq_l_n);

  assert_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_send_hit && r_take_hit) |=> !irq_r_n);

  assert_gate_l_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_en || l_sem) |-> (!l_send_hit && !l_take_hit));

  assert_gate_r_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_en || r_sem) |-> (!r_send_hit && !r_take_hit));

  assert_hold_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_send_hit && !r_take_hit) |=> $stable(irq_r_n));

  assert_hold_l_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_send_hit && !l_take_hit) |=> $stable(irq_l_n));

endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_addr(l_addr), .l_en(l_en), .l_sem(l_sem), .l_wr(l_wr),
  .r_addr(r_addr), .r_en(r_en), .r_sem(r_sem), .r_wr(r_wr),
  .irq_l_n(irq_l_n), .irq_r_n(irq_r_n),
  .l_send_hit(l_send_hit), .l_take_hit(l_take_hit),
  .r_send_hit(r_send_hit), .r_take_hit(r_take_hit)
);

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;

  localparam int AW = 15;
  localparam logic [AW-1:0] A_TOP = 15'h7FFF;
  localparam logic [AW-1:0] A_NXT = 15'h7FFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_en = 0, l_sem = 0, l_wr = 0, r_en = 0, r_sem = 0, r_wr = 0;
  logic irq_l_n, irq_r_n;

  int total = 0;
  int bad = 0;
  logic exp_l = 1'b0;  // expected flag toward left (1 = pending)
  logic exp_r = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  mbx_irq_top #(.ADDR_W(AW)) i_mbx_irq_top (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_en(l_en), .l_sem(l_sem), .l_wr(l_wr),
    .r_addr(r_addr), .r_en(r_en), .r_sem(r_sem), .r_wr(r_wr),
    .irq_l_n(irq_l_n), .irq_r_n(irq_r_n)
  );

  function automatic logic counts(logic en, logic sem);
    return en & ~sem;
  endfunction

  function automatic logic upd(logic cur, logic s, logic c);
    return s ? 1'b1 : (c ? 1'b0 : cur);
  endfunction

  task automatic check(string tag);
    total++;
    if (irq_l_n !== ~exp_l || irq_r_n !== ~exp_r) begin
      bad++;
      $display("FAIL %s: irq_l_n=%b irq_r_n=%b expected %b %b",
               tag, irq_l_n, irq_r_n, ~exp_l, ~exp_r);
    end
  endtask

  // Called at a falling edge: drive, pass one rising edge, compare.
  task automatic step(string tag,
                      logic [AW-1:0] la, logic le, logic ls, logic lw,
                      logic [AW-1:0] ra, logic re, logic rs, logic rw);
    logic sr, cr, sl, cl;
    l_addr = la; l_en = le; l_sem = ls; l_wr = lw;
    r_addr = ra; r_en = re; r_sem = rs; r_wr = rw;
    sr = counts(le, ls) && lw && (la == A_TOP);
    cr = counts(re, rs) && !rw && (ra == A_TOP);
    sl = counts(re, rs) && rw && (ra == A_NXT);
    cl = counts(le, ls) && !lw && (la == A_NXT);
    @(posedge clk);
    exp_r = upd(exp_r, sr, cr);
    exp_l = upd(exp_l, sl, cl);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [AW-1:0] pick_addr(int unsigned k);
    case (k % 5)
      0, 1: return A_TOP;
      2:    return A_NXT;
      3:    return A_TOP ^ AW'(1 << ($urandom % AW));
      default: return AW'($urandom);
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    step("R1 idle after reset", '0, 0, 0, 0, '0, 0, 0, 0);

    // Left mailbox to right
    step("R2 left write top", A_TOP, 1, 0, 1, '0, 0, 0, 0);
    step("R8 left read own send word", A_TOP, 1, 0, 0, '0, 0, 0, 0);
    step("R8 right write own take word", '0, 0, 0, 0, A_TOP, 1, 0, 1);
    step("R7 right read disabled", '0, 0, 0, 0, A_TOP, 0, 0, 0);
    step("R7 right read semaphore", '0, 0, 0, 0, A_TOP, 1, 1, 0);
    step("R8 right read near address", '0, 0, 0, 0, 15'h3FFF, 1, 0, 0);
    step("R3 right read top", '0, 0, 0, 0, A_TOP, 1, 0, 0);

    // Right mailbox to left
    step("R7 right write semaphore", '0, 0, 0, 0, A_NXT, 1, 1, 1);
    step("R4 right write next", '0, 0, 0, 0, A_NXT, 1, 0, 1);
    step("R8 left write own take word", A_NXT, 1, 0, 1, '0, 0, 0, 0);
    step("R7 left read disabled", A_NXT, 0, 0, 0, '0, 0, 0, 0);
    step("R5 left read next", A_NXT, 1, 0, 0, '0, 0, 0, 0);

    // Collisions
    step("R6 set and clear right, flag low", A_TOP, 1, 0, 1, A_TOP, 1, 0, 0);
    step("R6 set and clear right, flag high", A_TOP, 1, 0, 1, A_TOP, 1, 0, 0);
    step("R6 set and clear left", A_NXT, 1, 0, 0, A_NXT, 1, 0, 1);
    step("R3 clear right", '0, 0, 0, 0, A_TOP, 1, 0, 0);
    step("R5 clear left", A_NXT, 1, 0, 0, '0, 0, 0, 0);
    step("R7 left write top semaphore", A_TOP, 1, 1, 1, '0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      step("R2 R3 R4 R5 R6 R7 R8 random",
           pick_addr($urandom), 1'($urandom), 1'(($urandom % 6) == 0), 1'($urandom),
           pick_addr($urandom), 1'($urandom), 1'(($urandom % 6) == 0), 1'($urandom));
    end

    rst_n = 1'b0;
    exp_l = 1'b0; exp_r = 1'b0;
    #3;
    check("R1 reset mid run");
    @(negedge clk);
    rst_n = 1'b1;
    step("R1 idle after second reset", '0, 0, 0, 0, '0, 0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule